// File: doc/BRIEF.md
# Slave-Port Bus Arbiter

This block decides which of several bus masters owns one slave port of a multi-layer interconnect. Each cycle it looks at every master's request line and transfer status (transfer type, burst kind, and a predicted-last-beat flag for bursts of undefined length), together with the slave's ready signal. It then keeps a registered one-hot grant and the index of the owning master. A new owner is chosen only at cycles where a hand-over does no harm: the owner is idle, the owner is doing a single transfer, the owner is on the final beat of a burst, or the owner has held the port for the configured number of cycles.

Two selection policies are available. Round-robin rotates fairly among requesters. Fixed priority uses a per-master priority value. A default-master input names the master that takes the port when nobody asks for it. Address decoding, data steering and the slave itself live elsewhere. The predicted-last-beat flag comes from an outside predictor, one bit per master.

Top module: `slv_port_arbiter`

## Requirements
- R1: While `rst` is high at a rising edge, the grant moves to the master named by `dflt_mst`, and the index output carries that number.
- R2: `grant` always has exactly one bit set, at the position given by `grant_idx`.
- R3: Ownership changes only at a rising edge where `ready` is high. While `ready` is low, `grant` and `grant_idx` hold.
- R4: An owner driving transfer type IDLE (2'b00) lets arbitration happen at that edge.
- R5: An owner driving NONSEQ (2'b10) with burst kind SINGLE (3'b000) lets arbitration happen at that edge.
- R6: A fixed-length burst (burst codes 3'b010/3'b011 = 4 beats, 3'b100/3'b101 = 8, 3'b110/3'b111 = 16) is not handed over before its last beat. A beat completes on a ready-high cycle with type NONSEQ or SEQ (2'b11). Arbitration happens at the last beat. For a 16-beat burst with ready always high, the owner holds the port for exactly 16 cycles, plus one cycle for each ready-low cycle.
- R7: During an undefined-length burst (code 3'b001), hand-over happens only at an active beat where the owner's `mst_pred_end` bit is high. With the predictor flag never set, the burst keeps the port indefinitely unless R8 applies.
- R8: With `slot_limit` = L not equal to 0, the slot count restarts at every arbitration. When another master is waiting and `ready` is high, the owner loses the port after exactly L cycles. With L = 0 this break never happens.
- R9: With `fixed_mode` = 0 (round-robin), the winner is the first requesting master found when searching upward from the current owner's index + 1, wrapping around. The current owner is considered last.
- R10: With `fixed_mode` = 1, the winner is the requester with the largest `prio_cfg` field (field m at bits [4m+3:4m]). A tie goes to the lower index.
- R11: At an arbitration point with no request lines high, the port goes to the master named by `dflt_mst`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | N_MST | Request line, one bit per master |
| mst_trans | input | 2*N_MST | Transfer type per master, field m at [2m+1:2m] |
| mst_burst | input | 3*N_MST | Burst kind per master, field m at [3m+2:3m] |
| mst_pred_end | input | N_MST | Predicted last beat of an undefined-length burst, per master |
| ready | input | 1 | Slave ready; beats complete and grants change only when high |
| fixed_mode | input | 1 | 0 selects round-robin, 1 selects fixed priority |
| prio_cfg | input | PRIO_W*N_MST | Priority value per master |
| dflt_mst | input | IDX_W | Master that takes the port when no one requests |
| slot_limit | input | SLOT_W | Maximum ownership run in cycles; 0 disables the break |
| grant | output | N_MST | One-hot registered grant |
| grant_idx | output | IDX_W | Index of the owning master |

## Verification
A wrong beat count in the burst tracker shows up at the outputs on the edge where the burst should end. The grant moves one or more cycles early or late, so the ownership run length measured at `grant_idx` is off from 16. A slot counter that fails to clear or saturate changes the measured run length under a waiting competitor on the very next ownership run. A faulty search pointer shows up within one arbitration, as a grant sequence that does not step upward by one. A faulty priority compare shows up as a grant to a lower-priority requester at the next single transfer.

// File: rtl/arb_pkg.sv
package arb_pkg;

  localparam logic [1:0] TR_IDLE = 2'b00;
  localparam logic [1:0] TR_BUSY = 2'b01;
  localparam logic [1:0] TR_NSEQ = 2'b10;
  localparam logic [1:0] TR_SEQ  = 2'b11;

  localparam int BEAT_W = 5;

  // Beats in a burst kind; 0 marks undefined length
  function automatic logic [BEAT_W-1:0] burst_len(input logic [2:0] kind);
    case (kind)
      3'b000:         burst_len = 5'd1;
      3'b001:         burst_len = 5'd0;
      3'b010, 3'b011: burst_len = 5'd4;
      3'b100, 3'b101: burst_len = 5'd8;
      default:        burst_len = 5'd16;
    endcase
  endfunction

endpackage

// File: rtl/arb_burst_track.sv
module arb_burst_track
  import arb_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              ready,
  input  logic [1:0]        trans,
  input  logic [2:0]        burst,
  input  logic              pred_end,
  output logic [BEAT_W-1:0] beat_q,
  output logic              at_point
);

  logic [BEAT_W-1:0] len;
  logic              active;
  logic              pt_idle, pt_single, pt_fixed_end, pt_incr_end;

  assign len    = burst_len(burst);
  assign active = (trans == TR_NSEQ) || (trans == TR_SEQ);

  // Beats completed so far in the owner's current burst
  always_ff @(posedge clk) begin
    if (rst) begin
      beat_q <= '0;
    end else if (ready && trans == TR_NSEQ) begin
      beat_q <= {{(BEAT_W-1){1'b0}}, 1'b1};
    end else if (ready && trans == TR_SEQ && beat_q != '1) begin
      beat_q <= beat_q + 1'b1;
    end
  end

  assign pt_idle      = (trans == TR_IDLE);
  assign pt_single    = (trans == TR_NSEQ) && (len == 5'd1);
  assign pt_fixed_end = (trans == TR_SEQ) && (len > 5'd1) && (beat_q == len - 5'd1);
  assign pt_incr_end  = active && (len == 5'd0) && pred_end;
  assign at_point     = pt_idle || pt_single || pt_fixed_end || pt_incr_end;

endmodule

// File: rtl/arb_slot_timer.sv
module arb_slot_timer #(
  parameter int SLOT_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [SLOT_W-1:0] limit,
  input  logic              clear,
  output logic              hit
);

  logic [SLOT_W-1:0] run_q;

  // Cycles since the last arbitration, saturating
  always_ff @(posedge clk) begin
    if (rst || clear) begin
      run_q <= '0;
    end else if (run_q != '1) begin
      run_q <= run_q + 1'b1;
    end
  end

  assign hit = (limit != '0) && (run_q >= limit - 1'b1);

endmodule

// File: rtl/arb_select.sv
module arb_select #(
  parameter int N_MST  = 4,
  parameter int PRIO_W = 4,
  parameter int IDX_W  = 2
) (
  input  logic [N_MST-1:0]        req,
  input  logic [PRIO_W*N_MST-1:0] prio_cfg,
  input  logic                    fixed_mode,
  input  logic [IDX_W-1:0]        last_idx,
  input  logic [IDX_W-1:0]        dflt_mst,
  output logic [IDX_W-1:0]        win_idx
);

  logic [PRIO_W-1:0] prio_a [N_MST];
  logic [IDX_W-1:0]  rr_win, fp_win;
  logic [PRIO_W-1:0] fp_best;
  logic              rr_found, fp_found;

  for (genvar g = 0; g < N_MST; g++) begin : g_unpack
    assign prio_a[g] = prio_cfg[g*PRIO_W +: PRIO_W];
  end

  // Rotating search, starting one above the current owner
  always_comb begin
    rr_win   = dflt_mst;
    rr_found = 1'b0;
    for (int k = 1; k <= N_MST; k++) begin
      int j;
      j = (int'(last_idx) + k) % N_MST;
      if (!rr_found && req[j]) begin
        rr_win   = IDX_W'(j);
        rr_found = 1'b1;
      end
    end
  end

  // Largest value wins; strict compare keeps the lower index on a tie
  always_comb begin
    fp_win   = dflt_mst;
    fp_best  = '0;
    fp_found = 1'b0;
    for (int j = 0; j < N_MST; j++) begin
      if (req[j] && (!fp_found || prio_a[j] > fp_best)) begin
        fp_win   = IDX_W'(j);
        fp_best  = prio_a[j];
        fp_found = 1'b1;
      end
    end
  end

  assign win_idx = fixed_mode ? fp_win : rr_win;

endmodule

// File: rtl/slv_port_arbiter.sv
module slv_port_arbiter
  import arb_pkg::*;
#(
  parameter int N_MST  = 4,
  parameter int PRIO_W = 4,
  parameter int SLOT_W = 8,
  localparam int IDX_W = (N_MST > 1) ? $clog2(N_MST) : 1
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [N_MST-1:0]        req,
  input  logic [2*N_MST-1:0]      mst_trans,
  input  logic [3*N_MST-1:0]      mst_burst,
  input  logic [N_MST-1:0]        mst_pred_end,
  input  logic                    ready,
  input  logic                    fixed_mode,
  input  logic [PRIO_W*N_MST-1:0] prio_cfg,
  input  logic [IDX_W-1:0]        dflt_mst,
  input  logic [SLOT_W-1:0]       slot_limit,
  output logic [N_MST-1:0]        grant,
  output logic [IDX_W-1:0]        grant_idx
);

  logic [1:0]        own_trans;
  logic [2:0]        own_burst;
  logic              own_pred;
  logic [BEAT_W-1:0] own_len;
  logic [BEAT_W-1:0] beat_q;
  logic              at_point;
  logic              slot_hit;
  logic              arb_evt;
  logic [IDX_W-1:0]  win_idx;

  assign own_trans = mst_trans[int'(grant_idx)*2 +: 2];
  assign own_burst = mst_burst[int'(grant_idx)*3 +: 3];
  assign own_pred  = mst_pred_end[grant_idx];
  assign own_len   = burst_len(own_burst);

  arb_burst_track u_track (
    .clk      (clk),
    .rst      (rst),
    .ready    (ready),
    .trans    (own_trans),
    .burst    (own_burst),
    .pred_end (own_pred),
    .beat_q   (beat_q),
    .at_point (at_point)
  );

  arb_slot_timer #(.SLOT_W(SLOT_W)) u_slot (
    .clk   (clk),
    .rst   (rst),
    .limit (slot_limit),
    .clear (arb_evt),
    .hit   (slot_hit)
  );

  arb_select #(.N_MST(N_MST), .PRIO_W(PRIO_W), .IDX_W(IDX_W)) u_sel (
    .req        (req),
    .prio_cfg   (prio_cfg),
    .fixed_mode (fixed_mode),
    .last_idx   (grant_idx),
    .dflt_mst   (dflt_mst),
    .win_idx    (win_idx)
  );

  assign arb_evt = ready && (at_point || slot_hit);

  always_ff @(posedge clk) begin
    if (rst) begin
      grant_idx <= dflt_mst;
      grant     <= {{(N_MST-1){1'b0}}, 1'b1} << dflt_mst;
    end else if (arb_evt) begin
      grant_idx <= win_idx;
      grant     <= {{(N_MST-1){1'b0}}, 1'b1} << win_idx;
    end
  end

  AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    ($countones(grant) == 1) && grant[grant_idx]); // R2

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (rst)
    !ready |=> ($stable(grant_idx) && $stable(grant))); // R3

  AST_FIXED_BURST_HOLD: assert property (@(posedge clk) disable iff (rst)
    (ready && own_trans == TR_SEQ && own_len > 5'd1 && beat_q < own_len - 5'd1 && !slot_hit)
      |=> $stable(grant_idx)); // R6

  AST_IDLE_DEFAULT: assert property (@(posedge clk) disable iff (rst)
    (ready && own_trans == TR_IDLE && req == '0) |=> (grant_idx == $past(dflt_mst))); // R11

  AST_WINNER_REQUESTS: assert property (@(posedge clk) disable iff (rst)
    (ready && (at_point || slot_hit) && req != '0) |=> ((grant & $past(req)) != '0)); // R9

endmodule

// File: tb/slv_port_arbiter_bench.sv
module slv_port_arbiter_bench;

  localparam int N = 4;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [N-1:0] req = '0;
  logic [2*N-1:0] mst_trans = '0;
  logic [3*N-1:0] mst_burst = '0;
  logic [N-1:0] mst_pred_end = '0;
  logic         ready = 1'b1;
  logic         fixed_mode = 1'b0;
  logic [4*N-1:0] prio_cfg = '0;
  logic [1:0]   dflt_mst = 2'd2;
  logic [7:0]   slot_limit = '0;
  logic [N-1:0] grant;
  logic [1:0]   grant_idx;

  int n_chk = 0;
  int n_err = 0;
  bit done  = 0;

  // Master model state
  bit       pend [N]   = '{default: 0};
  bit       keep [N]   = '{default: 0};
  int       blen [N]   = '{default: 1};
  logic [2:0] bcode [N] = '{default: 3'b000};
  int       pper [N]   = '{default: 0};
  int       beat [N]   = '{default: 0};
  bit       own_q [N]  = '{default: 0};
  bit       ready_q    = 1'b1;
  bit       ready_n    = 1'b1;

  always #2 clk = ~clk;

  slv_port_arbiter u_slv_port_arbiter (
    .clk          (clk),
    .rst          (rst),
    .req          (req),
    .mst_trans    (mst_trans),
    .mst_burst    (mst_burst),
    .mst_pred_end (mst_pred_end),
    .ready        (ready),
    .fixed_mode   (fixed_mode),
    .prio_cfg     (prio_cfg),
    .dflt_mst     (dflt_mst),
    .slot_limit   (slot_limit),
    .grant        (grant),
    .grant_idx    (grant_idx)
  );

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // One cycle: account for the beat just finished, then drive the next one
  task automatic cycle();
    @(negedge clk);
    for (int m = 0; m < N; m++) begin
      if (own_q[m] && ready_q && pend[m]) begin
        beat[m]++;
        if (blen[m] != 0 && beat[m] == blen[m]) begin
          beat[m] = 0;
          if (!keep[m]) pend[m] = 0;
        end
      end
    end
    for (int m = 0; m < N; m++) begin
      bit own;
      own = (int'(grant_idx) == m);
      mst_burst[m*3 +: 3] = bcode[m];
      if (!pend[m]) begin
        req[m] = 1'b0;
        mst_trans[m*2 +: 2] = 2'b00;
        mst_pred_end[m] = 1'b0;
        own_q[m] = 1'b0;
      end else begin
        req[m] = 1'b1;
        if (!own) beat[m] = 0;
        mst_trans[m*2 +: 2] = (beat[m] == 0) ? 2'b10 : 2'b11;
        mst_pred_end[m] = own && pper[m] != 0 && ((beat[m] + 1) % pper[m] == 0);
        own_q[m] = own;
      end
    end
    ready   = ready_n;
    ready_q = ready_n;
  endtask

  task automatic idle_all();
    for (int m = 0; m < N; m++) begin
      pend[m] = 0; keep[m] = 0; pper[m] = 0; blen[m] = 1; bcode[m] = 3'b000;
    end
    repeat (3) cycle();
  endtask

  task automatic set_single(input int m);
    pend[m] = 1; keep[m] = 1; blen[m] = 1; bcode[m] = 3'b000; pper[m] = 0;
  endtask

  // Length of the next complete ownership run of master m, capped
  task automatic measure(input int m, input int cap, output int len);
    int guard = 0;
    while (int'(grant_idx) == m && guard < 200) begin cycle(); guard++; end
    while (int'(grant_idx) != m && guard < 200) begin cycle(); guard++; end
    len = 1;
    while (len < cap) begin
      cycle();
      if (int'(grant_idx) == m) len++;
      else break;
    end
  endtask

  task automatic t_reset();
    rst = 1'b1;
    repeat (3) cycle();
    check("R1 index under reset", int'(grant_idx), 2);
    check("R2 one-hot under reset", int'(grant), 4);
    rst = 1'b0;
    repeat (3) cycle();
    check("R11 idle stays on default", int'(grant_idx), 2);
  endtask

  task automatic t_default();
    dflt_mst = 2'd3;
    repeat (2) cycle();
    check("R4 R11 idle hands to new default", int'(grant_idx), 3);
    check("R2 one-hot after default move", int'(grant), 8);
  endtask

  task automatic t_round_robin();
    int prev;
    for (int m = 0; m < N; m++) set_single(m);
    repeat (3) cycle();
    prev = int'(grant_idx);
    for (int i = 0; i < 8; i++) begin
      cycle();
      check("R5 R9 rotation step", int'(grant_idx), (prev + 1) % N);
      prev = int'(grant_idx);
    end
    ready_n = 1'b0;
    cycle();
    prev = int'(grant_idx);
    for (int i = 0; i < 3; i++) begin
      cycle();
      check("R3 hold while not ready", int'(grant_idx), prev);
    end
    ready_n = 1'b1;
    idle_all();
    set_single(0);
    set_single(2);
    repeat (3) cycle();
    prev = int'(grant_idx);
    for (int i = 0; i < 6; i++) begin
      cycle();
      check("R9 skip idle masters", int'(grant_idx), (prev == 0) ? 2 : 0);
      prev = int'(grant_idx);
    end
    idle_all();
  endtask

  task automatic t_fixed();
    fixed_mode = 1'b1;
    prio_cfg = {4'd2, 4'd3, 4'd3, 4'd1};
    for (int m = 0; m < N; m++) set_single(m);
    repeat (3) cycle();
    for (int i = 0; i < 4; i++) begin
      cycle();
      check("R10 tie to lower index", int'(grant_idx), 1);
    end
    prio_cfg = {4'd5, 4'd3, 4'd3, 4'd1};
    repeat (2) cycle();
    for (int i = 0; i < 3; i++) begin
      cycle();
      check("R10 highest value wins", int'(grant_idx), 3);
    end
    idle_all();
    fixed_mode = 1'b0;
    repeat (2) cycle();
  endtask

  task automatic t_burst16();
    int own = 0;
    int guard = 0;
    slot_limit = 8'd0;
    pend[0] = 1; keep[0] = 0; blen[0] = 16; bcode[0] = 3'b111; pper[0] = 0;
    while (int'(grant_idx) != 0 && guard < 20) begin cycle(); guard++; end
    own = 1;
    set_single(1);
    while (own < 60) begin
      ready_n = (own >= 5 && own < 8) ? 1'b0 : 1'b1;
      cycle();
      if (int'(grant_idx) == 0) own++;
      else break;
    end
    ready_n = 1'b1;
    check("R6 R3 16-beat run with 3 stalls", own, 19);
    check("R9 waiting master next", int'(grant_idx), 1);
    idle_all();
  endtask

  task automatic t_incr();
    int len;
    pend[0] = 1; keep[0] = 1; blen[0] = 0; bcode[0] = 3'b001; pper[0] = 4;
    set_single(1);
    measure(0, 40, len);
    check("R7 predicted end every 4 beats", len, 4);
    measure(0, 40, len);
    check("R7 predicted end again", len, 4);
    pper[0] = 0;
    measure(0, 40, len);
    check("R7 no prediction keeps port", len, 40);
  endtask

  task automatic t_slot();
    int len;
    slot_limit = 8'd6;
    measure(0, 40, len);
    check("R8 slot break at 6", len, 6);
    measure(0, 40, len);
    check("R8 slot break repeats", len, 6);
    slot_limit = 8'd1;
    measure(0, 40, len);
    check("R8 slot break at 1", len, 1);
    slot_limit = 8'd0;
    measure(0, 40, len);
    check("R8 limit 0 disables break", len, 40);
    idle_all();
  endtask

  initial begin
    t_reset();
    t_default();
    t_round_robin();
    t_fixed();
    t_burst16();
    t_incr();
    t_slot();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

endmodule